// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the shifting core of a serial peripheral master. One `go` pulse starts a burst of one or two transactions. Each transaction moves one word of 1 to 32 bits, most significant bit first. The engine drives the serial clock from a fixed divider of the system clock, with a selectable idle level. It drives the slave-select line and shifts data out and in through plain parallel transmit and receive registers. The settings are taken from the configuration inputs on the cycle `go` is accepted and are held until the burst ends.

The engine can stretch the idle time between the two transactions of a burst, and between the bytes of a 32-bit word, by a programmable number of serial clock periods. It can send and receive the bytes of a word least significant byte first. A two-line mode moves two words at once on two output and two input lines. At the end of a burst a sticky completion flag is set. It stays set until it is cleared by a write-one pulse. An interrupt output is high while the flag and the interrupt enable are both high.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset, `ss_n` is 1, `sclk`, `busy`, `done_flag`, `irq`, `mosi`, `rx0` and `rx1` are all 0.
- R2: While idle, `sclk` follows `cfg_cpol` within one clock (0 gives a low idle level, 1 a high one). In a burst, every bit has one leading edge (away from the idle level) and then one trailing edge.
- R3: Data goes out on `mosi[0]`, most significant used bit first. A bit is placed on the line at its leading edge. `miso[0]` is sampled at the trailing edge into the same bit position of the receive register. All receive bits above the word length read 0 after the burst.
- R4: `cfg_len` gives the word length: 1 to 31 bits as written, and 0 means 32 bits.
- R5: Every half period of `sclk` lasts HALF_DIV clocks. `ss_n` falls HALF_DIV clocks before the first leading edge. Between bytes and between bits with no pause, a trailing edge is followed by the next leading edge HALF_DIV clocks later.
- R6: With `cfg_two_txn` = 1 (single-line mode), the burst has two transactions: `tx0`/`rx0` first, then `tx1`/`rx1`. From the last trailing edge of the first transaction to the first leading edge of the second there are 2*(`cfg_sleep`+2)*HALF_DIV clocks, and `ss_n` stays low throughout. With 0 there is one transaction and `rx1` reads 0.
- R7: With `cfg_byte_pause` = 1 and a 32-bit word, the same pause of (`cfg_sleep`+2) serial periods follows the trailing edges of bits 7, 15 and 23 of each word. At any other length the setting has no effect.
- R8: With `cfg_lsb_first` = 1 and a length that is a multiple of 8, bytes go out and come in starting with bits 7:0, then 15:8 and so on, each byte most significant bit first. At other lengths the setting has no effect.
- R9: With `cfg_dual` = 1, `mosi[0]` carries `tx0` and `mosi[1]` carries `tx1` at the same time, and `miso[0]` fills `rx0` while `miso[1]` fills `rx1`. The burst is then one transaction whatever `cfg_two_txn` says. In single-line mode `mosi[1]` stays 0.
- R10: `busy` is high from the clock after `go` is accepted until the clock of the final trailing edge. On that same clock `ss_n` rises and `done_flag` is set.
- R11: A `go` pulse while `busy` is high, together with new transmit data, has no effect on the burst in progress.
- R12: `done_flag` stays set until `flag_w1c` is high at a clock edge. If the flag is set and cleared on the same edge, it ends up set. `irq` equals `done_flag` AND `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse, taken only while idle |
| cfg_len | input | 5 | Word length, 0 means 32 |
| cfg_two_txn | input | 1 | 1 = two transactions per burst |
| cfg_sleep | input | 4 | Pause length selector, (value+2) serial periods |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_dual | input | 1 | Two-line data mode |
| cfg_byte_pause | input | 1 | Pause between bytes of 32-bit words |
| cfg_lsb_first | input | 1 | Least significant byte first |
| irq_en | input | 1 | Interrupt enable |
| flag_w1c | input | 1 | Clears the completion flag |
| tx0 | input | 32 | Transmit word 0 |
| tx1 | input | 32 | Transmit word 1 |
| miso | input | 2 | Serial data in, line 1 used in two-line mode |
| busy | output | 1 | Burst in progress |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| ss_n | output | 1 | Slave select, active low |
| mosi | output | 2 | Serial data out |
| rx0 | output | 32 | Receive word 0 |
| rx1 | output | 32 | Receive word 1 |

## Verification
Most internal faults show up as timing faults at the ports. A wrong bit or transaction counter changes the number of leading edges in the burst. A wrong pause count moves the next leading edge by whole half periods, so it is visible at the first byte or transaction boundary, within one word. A wrong bit-position mapping sends a permuted word on `mosi` and stores the same permutation in the receive register. The bench therefore compares every transmitted bit and both received words with a slave model that uses pseudo-random data. A wrong end-of-burst decision shows on the final edge, as a `busy`, `ss_n` or `done_flag` that does not change on that clock.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    localparam int WORD_W = 32;
    localparam int IDX_W  = $clog2(WORD_W);
    localparam int LEN_W  = IDX_W + 1;
    localparam int SLP_W  = 4;
    localparam int GAP_W  = SLP_W + 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ACT
    } seq_state_t;

    typedef struct packed {
        logic [LEN_W-1:0] len;        // decoded length, 1..WORD_W
        logic             last_txn;   // index of the final transaction
        logic [SLP_W-1:0] sleep;
        logic             cpol;
        logic             dual;
        logic             byte_pause;
        logic             lsb_first;
    } xfer_cfg_t;

    // length field: zero stands for a full word
    function automatic logic [LEN_W-1:0] decode_len(input logic [IDX_W-1:0] f);
        return (f == '0) ? LEN_W'(WORD_W) : {1'b0, f};
    endfunction

    // pause in half periods: 2 * (sleep + 2)
    function automatic logic [GAP_W-1:0] gap_halves(input logic [SLP_W-1:0] s);
        return ({2'b00, s} + GAP_W'(2)) << 1;
    endfunction

    // register position of the k-th bit on the wire
    function automatic logic [IDX_W-1:0] bit_pos(input logic [IDX_W-1:0] k,
                                                 input logic [LEN_W-1:0] len,
                                                 input logic             lsbf);
        logic [LEN_W-1:0] t;
        t = len - LEN_W'(1) - {1'b0, k};
        if (lsbf && (len[2:0] == 3'b000))
            return {k[IDX_W-1:3], ~k[2:0]};
        return t[IDX_W-1:0];
    endfunction

endpackage

// File: rtl/spi_xfer_clkdiv.sv
module spi_xfer_clkdiv #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] hcnt;

    assign tick = run && (hcnt == CW'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run)
            hcnt <= '0;
        else if (tick)
            hcnt <= '0;
        else
            hcnt <= hcnt + CW'(1);
    end
endmodule

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
    import spi_xfer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  xfer_cfg_t        cfg_in,
    input  logic             tick,
    output logic             start,
    output logic             busy,
    output logic             ss_n,
    output logic             sclk,
    output logic             lead,
    output logic             trail,
    output logic             finish,
    output logic [IDX_W-1:0] bit_k,
    output logic             txn,
    output xfer_cfg_t        cfg_q
);
    seq_state_t       state;
    logic [GAP_W-1:0] wait_left;
    logic             last_bit;
    logic             last_txn;
    logic             pause_here;

    assign last_bit   = ({1'b0, bit_k} == (cfg_q.len - LEN_W'(1)));
    assign last_txn   = (txn == cfg_q.last_txn);
    assign pause_here = cfg_q.byte_pause && (cfg_q.len == LEN_W'(WORD_W))
                        && (bit_k[2:0] == 3'b111);

    assign start  = go && (state == ST_IDLE);
    assign busy   = (state != ST_IDLE);
    assign lead   = tick && (state == ST_WAIT) && (wait_left == GAP_W'(1));
    assign trail  = tick && (state == ST_ACT);
    assign finish = trail && last_bit && last_txn;
    assign sclk   = sclk_q;
    assign ss_n   = ss_n_q;

    logic sclk_q;
    logic ss_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            wait_left <= '0;
            bit_k     <= '0;
            txn       <= 1'b0;
            cfg_q     <= '0;
            sclk_q    <= 1'b0;
            ss_n_q    <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    sclk_q <= cfg_in.cpol;
                    if (go) begin
                        cfg_q     <= cfg_in;
                        state     <= ST_WAIT;
                        wait_left <= GAP_W'(1);
                        bit_k     <= '0;
                        txn       <= 1'b0;
                        ss_n_q    <= 1'b0;
                    end
                end
                ST_WAIT: begin
                    if (tick) begin
                        if (wait_left == GAP_W'(1)) begin
                            state  <= ST_ACT;
                            sclk_q <= ~cfg_q.cpol;
                        end else begin
                            wait_left <= wait_left - GAP_W'(1);
                        end
                    end
                end
                ST_ACT: begin
                    if (tick) begin
                        sclk_q <= cfg_q.cpol;
                        if (last_bit && last_txn) begin
                            state  <= ST_IDLE;
                            ss_n_q <= 1'b1;
                        end else if (last_bit) begin
                            txn       <= 1'b1;
                            bit_k     <= '0;
                            state     <= ST_WAIT;
                            wait_left <= gap_halves(cfg_q.sleep);
                        end else begin
                            bit_k     <= bit_k + IDX_W'(1);
                            state     <= ST_WAIT;
                            wait_left <= pause_here ? gap_halves(cfg_q.sleep) : GAP_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_xfer_shift.sv
module spi_xfer_shift
    import spi_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] tx0,
    input  logic [WORD_W-1:0] tx1,
    input  logic [LEN_W-1:0]  len,
    input  logic              lsb_first,
    input  logic              dual,
    input  logic              lead,
    input  logic              trail,
    input  logic [IDX_W-1:0]  bit_k,
    input  logic              txn,
    input  logic [1:0]        miso,
    output logic [1:0]        mosi,
    output logic [WORD_W-1:0] rx0,
    output logic [WORD_W-1:0] rx1
);
    logic [WORD_W-1:0] txq0;
    logic [WORD_W-1:0] txq1;
    logic [IDX_W-1:0]  pos;

    assign pos = bit_pos(bit_k, len, lsb_first);

    always_ff @(posedge clk) begin
        if (rst) begin
            txq0 <= '0;
            txq1 <= '0;
            rx0  <= '0;
            rx1  <= '0;
            mosi <= '0;
        end else if (start) begin
            txq0 <= tx0;
            txq1 <= tx1;
            rx0  <= '0;
            rx1  <= '0;
            mosi <= '0;
        end else begin
            if (lead) begin
                if (dual)
                    mosi <= {txq1[pos], txq0[pos]};
                else
                    mosi <= {1'b0, (txn ? txq1[pos] : txq0[pos])};
            end
            if (trail) begin
                if (dual) begin
                    rx0[pos] <= miso[0];
                    rx1[pos] <= miso[1];
                end else if (txn) begin
                    rx1[pos] <= miso[0];
                end else begin
                    rx0[pos] <= miso[0];
                end
            end
        end
    end
endmodule

// File: rtl/spi_xfer_flag.sv
module spi_xfer_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic en,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    assign irq = flag && en;
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_xfer_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        go,
    input  logic [4:0]  cfg_len,
    input  logic        cfg_two_txn,
    input  logic [3:0]  cfg_sleep,
    input  logic        cfg_cpol,
    input  logic        cfg_dual,
    input  logic        cfg_byte_pause,
    input  logic        cfg_lsb_first,
    input  logic        irq_en,
    input  logic        flag_w1c,
    input  logic [31:0] tx0,
    input  logic [31:0] tx1,
    input  logic [1:0]  miso,
    output logic        busy,
    output logic        done_flag,
    output logic        irq,
    output logic        sclk,
    output logic        ss_n,
    output logic [1:0]  mosi,
    output logic [31:0] rx0,
    output logic [31:0] rx1
);
    xfer_cfg_t        cfg_in;
    xfer_cfg_t        cfg_q;
    logic             tick;
    logic             start;
    logic             lead;
    logic             trail;
    logic             finish;
    logic [IDX_W-1:0] bit_k;
    logic             txn;

    always_comb begin
        cfg_in.len        = decode_len(cfg_len);
        cfg_in.last_txn   = cfg_dual ? 1'b0 : cfg_two_txn;
        cfg_in.sleep      = cfg_sleep;
        cfg_in.cpol       = cfg_cpol;
        cfg_in.dual       = cfg_dual;
        cfg_in.byte_pause = cfg_byte_pause;
        cfg_in.lsb_first  = cfg_lsb_first;
    end

    spi_xfer_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    spi_xfer_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .go     (go),
        .cfg_in (cfg_in),
        .tick   (tick),
        .start  (start),
        .busy   (busy),
        .ss_n   (ss_n),
        .sclk   (sclk),
        .lead   (lead),
        .trail  (trail),
        .finish (finish),
        .bit_k  (bit_k),
        .txn    (txn),
        .cfg_q  (cfg_q)
    );

    spi_xfer_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .tx0       (tx0),
        .tx1       (tx1),
        .len       (cfg_q.len),
        .lsb_first (cfg_q.lsb_first),
        .dual      (cfg_q.dual),
        .lead      (lead),
        .trail     (trail),
        .bit_k     (bit_k),
        .txn       (txn),
        .miso      (miso),
        .mosi      (mosi),
        .rx0       (rx0),
        .rx1       (rx1)
    );

    spi_xfer_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (finish),
        .clr  (flag_w1c),
        .en   (irq_en),
        .flag (done_flag),
        .irq  (irq)
    );
endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic ss_n,
    input logic sclk,
    input logic cfg_cpol,
    input logic done_flag,
    input logic flag_w1c
);
    // R1: reset leaves the port state idle
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (ss_n && !busy && !done_flag));

    // R2: idle clock level follows polarity input
    a_r2_idle_level: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy) && !$past(rst)) |-> (sclk == $past(cfg_cpol)));

    // R10: select active exactly while busy
    a_r10_select_busy: assert property (@(posedge clk) disable iff (rst)
        ss_n == !busy);

    // R10: end of burst raises the flag
    a_r10_flag_at_end: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done_flag);

    // R12: flag holds without a clear
    a_r12_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (done_flag && !flag_w1c) |=> done_flag);

    // R12: clear while idle empties the flag
    a_r12_flag_clear: assert property (@(posedge clk) disable iff (rst)
        (flag_w1c && !busy) |=> !done_flag);
endmodule

bind spi_xfer_engine spi_xfer_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .ss_n      (ss_n),
    .sclk      (sclk),
    .cfg_cpol  (cfg_cpol),
    .done_flag (done_flag),
    .flag_w1c  (flag_w1c)
);

// File: tb/spi_xfer_engine_bench.sv
module spi_xfer_engine_bench;
    localparam int HD = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        go = 1'b0;
    logic [4:0]  cfg_len = '0;
    logic        cfg_two_txn = 1'b0;
    logic [3:0]  cfg_sleep = '0;
    logic        cfg_cpol = 1'b0;
    logic        cfg_dual = 1'b0;
    logic        cfg_byte_pause = 1'b0;
    logic        cfg_lsb_first = 1'b0;
    logic        irq_en = 1'b0;
    logic        flag_w1c = 1'b0;
    logic [31:0] tx0 = '0;
    logic [31:0] tx1 = '0;
    logic [1:0]  miso = '0;
    logic        busy, done_flag, irq, sclk, ss_n;
    logic [1:0]  mosi;
    logic [31:0] rx0, rx1;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    spi_xfer_engine #(.HALF_DIV(HD)) u_spi_xfer_engine (
        .clk(clk), .rst(rst), .go(go), .cfg_len(cfg_len), .cfg_two_txn(cfg_two_txn),
        .cfg_sleep(cfg_sleep), .cfg_cpol(cfg_cpol), .cfg_dual(cfg_dual),
        .cfg_byte_pause(cfg_byte_pause), .cfg_lsb_first(cfg_lsb_first),
        .irq_en(irq_en), .flag_w1c(flag_w1c), .tx0(tx0), .tx1(tx1), .miso(miso),
        .busy(busy), .done_flag(done_flag), .irq(irq), .sclk(sclk), .ss_n(ss_n),
        .mosi(mosi), .rx0(rx0), .rx1(rx1)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // wire order of a word: k-th bit sent lives at this register position
    function automatic int wire_pos(input int k, input int len, input bit lsbf);
        if (lsbf && (len % 8 == 0)) return (k / 8) * 8 + (7 - (k % 8));
        return len - 1 - k;
    endfunction

    function automatic logic [31:0] low_bits(input logic [31:0] v, input int len);
        if (len >= 32) return v;
        return v & ((32'h1 << len) - 32'h1);
    endfunction

    task automatic do_xfer(input logic [4:0] lf, input bit cnt, input logic [3:0] slp,
                           input bit cp, input bit dl, input bit bp, input bit lsbf,
                           input bit ie, input logic [31:0] t0, input logic [31:0] t1,
                           input logic [31:0] m0, input logic [31:0] m1,
                           input bit mid_go, input bit hold_clr);
        int L, ntx, gap, nl, nt, ss_t, done_t, bad_data, bad_mosi1, bad_half;
        int bad_txgap, bad_bytegap, bad_plain;
        bit ss_hi, prev, seen_end;
        int lt[64];
        int tt[64];
        logic [1:0] mo[64];
        string dtag;
        L = (lf == 0) ? 32 : int'(lf);
        ntx = dl ? 1 : (cnt ? 2 : 1);
        gap = 2 * (int'(slp) + 2) * HD;
        nl = 0; nt = 0; ss_t = -1; done_t = -1; ss_hi = 0; seen_end = 0;
        @(negedge clk);
        cfg_len = lf; cfg_two_txn = cnt; cfg_sleep = slp; cfg_cpol = cp; cfg_dual = dl;
        cfg_byte_pause = bp; cfg_lsb_first = lsbf; irq_en = ie; tx0 = t0; tx1 = t1;
        flag_w1c = hold_clr;
        @(negedge clk);
        prev = sclk;
        go = 1'b1;
        for (int it = 0; it < 8000; it++) begin
            @(negedge clk);
            if (go) go = 1'b0;
            if (ss_t < 0 && !ss_n) ss_t = cyc;
            if (sclk != prev) begin
                if (sclk != cp) begin
                    int n, tr, p;
                    n = nl; tr = n / L; p = wire_pos(n % L, L, lsbf);
                    if (nl < 64) begin lt[nl] = cyc; mo[nl] = mosi; end
                    nl++;
                    miso[0] = (dl || tr == 0) ? m0[p] : m1[p];
                    miso[1] = m1[p];
                    if (mid_go && nl == 3) begin go = 1'b1; tx0 = ~t0; tx1 = ~t1; end
                end else begin
                    if (nt < 64) tt[nt] = cyc;
                    nt++;
                end
                prev = sclk;
            end
            if (!busy) begin done_t = cyc; seen_end = 1; break; end
            if (ss_n) ss_hi = 1;
        end
        go = 1'b0;
        check(seen_end, "R10 burst ends", seen_end, 1);
        // R4 / R2: edge counts
        check(nl == L * ntx, "R4 leading edge count", nl, L * ntx);
        check(nt == nl, "R2 trailing edges pair leading edges", nt, nl);
        if (mid_go) check(nl == L * ntx, "R11 go while busy keeps burst", nl, L * ntx);
        // data on the wire
        bad_data = 0; bad_mosi1 = 0;
        for (int n = 0; n < nl && n < 64 && n < L * ntx; n++) begin
            int tr, p;
            logic e0;
            tr = n / L; p = wire_pos(n % L, L, lsbf);
            e0 = (dl || tr == 0) ? t0[p] : t1[p];
            if (mo[n][0] !== e0) bad_data++;
            if (mo[n][1] !== (dl ? t1[p] : 1'b0)) bad_mosi1++;
        end
        dtag = dl ? "R9 two-line data" : ((lsbf && L % 8 == 0) ? "R8 byte reorder data" : "R3 serial data");
        if (mid_go) dtag = "R11 data unchanged by late go";
        check(bad_data == 0, dtag, bad_data, 0);
        check(bad_mosi1 == 0, "R9 second output line", bad_mosi1, 0);
        check(rx0 === low_bits(m0, L), "R3 receive word 0", rx0, low_bits(m0, L));
        check(rx1 === ((ntx == 2 || dl) ? low_bits(m1, L) : 32'h0),
              dl ? "R9 receive word 1" : "R6 receive word 1", rx1,
              (ntx == 2 || dl) ? low_bits(m1, L) : 32'h0);
        // timing
        bad_half = 0; bad_txgap = 0; bad_bytegap = 0; bad_plain = 0;
        for (int n = 0; n < nl && n < nt && n < 64; n++)
            if (tt[n] - lt[n] != HD) bad_half++;
        for (int n = 1; n < nl && n < 64; n++) begin
            int d;
            d = lt[n] - tt[n-1];
            if (n % L == 0) begin
                if (d != gap) bad_txgap++;
            end else if (n % 8 == 0 && bp) begin
                if (d != ((L == 32) ? gap : HD)) bad_bytegap++;
            end else if (d != HD) bad_plain++;
        end
        check(nl > 0 && lt[0] - ss_t == HD, "R5 select lead time", nl > 0 ? lt[0] - ss_t : -1, HD);
        check(bad_half == 0 && bad_plain == 0, "R5 half period spacing", bad_half + bad_plain, 0);
        if (ntx == 2) check(bad_txgap == 0, "R6 transaction gap", bad_txgap, 0);
        if (bp) check(bad_bytegap == 0, "R7 byte pause", bad_bytegap, 0);
        check(!ss_hi, "R6 select held low in burst", ss_hi, 0);
        // end of burst
        check(nt > 0 && nt <= 64 && done_t == tt[nt-1], "R10 busy drops on final edge",
              done_t, (nt > 0 && nt <= 64) ? tt[nt-1] : -1);
        check(ss_n === 1'b1 && done_flag === 1'b1, "R10 select and flag at end",
              {ss_n, done_flag}, 2'b11);
        check(irq === ie, "R12 interrupt follows enable", irq, ie);
        if (hold_clr) begin
            @(negedge clk);
            check(done_flag === 1'b0, "R12 held clear empties flag", done_flag, 0);
            flag_w1c = 1'b0;
        end else begin
            @(negedge clk);
            check(done_flag === 1'b1, "R12 flag sticky", done_flag, 1);
            flag_w1c = 1'b1;
            @(negedge clk);
            flag_w1c = 1'b0;
            check(done_flag === 1'b0 && irq === 1'b0, "R12 write-one clear", {done_flag, irq}, 0);
        end
    endtask

    initial begin
        #1_900_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(ss_n === 1'b1 && sclk === 1'b0 && busy === 1'b0, "R1 reset lines",
              {ss_n, sclk, busy}, 3'b100);
        check(done_flag === 1'b0 && irq === 1'b0 && mosi === 2'b00, "R1 reset flag",
              {done_flag, irq, mosi}, 0);
        check(rx0 === 32'h0 && rx1 === 32'h0, "R1 reset receive", rx0 | rx1, 0);
        // R2 idle levels
        cfg_cpol = 1'b1;
        @(negedge clk); @(negedge clk);
        check(sclk === 1'b1, "R2 idle high", sclk, 1);
        cfg_cpol = 1'b0;
        @(negedge clk); @(negedge clk);
        check(sclk === 1'b0, "R2 idle low", sclk, 0);

        // directed corners
        do_xfer(5'd8,  0, 4'd0, 0, 0, 0, 0, 1, 32'hA5, 32'h0, 32'h3C, 32'h0, 0, 0);
        do_xfer(5'd1,  0, 4'd0, 1, 0, 0, 0, 0, 32'h1, 32'h0, 32'h1, 32'h0, 0, 0);
        do_xfer(5'd0,  0, 4'd3, 0, 0, 1, 1, 1, 32'h12345678, 32'h0, 32'hCAFEF00D, 32'h0, 0, 0);
        do_xfer(5'd12, 0, 4'd5, 1, 0, 1, 1, 0, 32'hABC, 32'h0, 32'h5A5, 32'h0, 0, 0);
        do_xfer(5'd16, 1, 4'd15, 0, 0, 0, 1, 1, 32'hBEEF, 32'h1234, 32'h0F0F, 32'hF00F, 0, 0);
        do_xfer(5'd24, 1, 4'd2, 1, 1, 0, 0, 1, 32'h00AA55, 32'h0055AA, 32'h123456, 32'h654321, 0, 0);
        do_xfer(5'd20, 1, 4'd1, 0, 0, 0, 0, 0, 32'h9ABCD, 32'h13579, 32'h2468A, 32'hFEDCB, 1, 0);
        do_xfer(5'd6,  0, 4'd0, 0, 0, 0, 0, 1, 32'h2B, 32'h0, 32'h15, 32'h0, 0, 1);

        // constrained random
        for (int i = 0; i < 40; i++) begin
            logic [4:0] lf;
            logic [3:0] sl;
            lf = 5'($urandom_range(0, 31));
            sl = 4'($urandom_range(0, 15));
            do_xfer(lf, 1'($urandom), sl, 1'($urandom), 1'($urandom_range(0, 3) == 0),
                    1'($urandom), 1'($urandom), 1'($urandom),
                    $urandom, $urandom, $urandom, $urandom, 0, 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule